// File: doc/BRIEF.md
# Chip Reset Sequencer with Register Access Gate

This block runs the reset sequence of a small device. A power-on indication or an external active-low reset pin starts it. The pin is synchronized and has to stay low for a minimum number of cycles before it counts as a reset. A chip reset clears all internal state and raises two internal reset outputs. The interface reset is held for a fixed number of cycles. The block then captures the configuration strap inputs and sends a start pulse to an external configuration loader.

The loader answers with a done handshake and the number of bytes it moved. The block then waits out a base delay plus a per-byte delay, both counted in clock cycles from the start of the load phase. After that it reports ready. A new reset event in any state sends the sequence back to its first state.

The block also gates a small register bus while the sequence runs. Before ready, only three registers can be read: the byte-order test word, the hardware configuration word and the reset control word. Any other read returns zero and raises an error flag for one cycle. Every write is dropped until ready. The byte-order word reads as all ones until the interface reset phase is over, and as a fixed parameter pattern after that.

Top module: `chip_reset_sequencer`

## Requirements
- R1: A high `por_i`, or `ext_rst_n_i` held low for at least MIN_LOW_CYC synchronized cycles, resets the block from any state. While the event lasts, `ready_o` is 0 and `rst_if_o` and `rst_core_o` are 1, and the scratch register (word address 3) returns to 0.
- R2: A low pulse on `ext_rst_n_i` shorter than MIN_LOW_CYC cycles has no effect: `ready_o` stays 1 and the scratch register keeps its value.
- R3: `strap_i` is captured once per sequence, at the end of the interface phase. The hardware configuration word (address 1) shows the captured value in bits [8 +: STRAP_W]. A later change of `strap_i` does not change it.
- R4: `ld_start_o` is a pulse one cycle wide, issued exactly once per reset sequence and only after the interface phase.
- R5: `ready_o`, mirrored in bit 0 of address 1, stays 0 until the loader has signalled done and BASE_WAIT_CYC + bytes × PER_BYTE_CYC cycles have passed since the load phase began. If done arrives early, `ready_o` rises exactly that many cycles plus two after the `ld_start_o` cycle. If done arrives late, it rises two cycles after done.
- R6: While `ready_o` is 0, a read of any address other than 0, 1 or 2 returns zero with `bus_err_o` high for exactly that one response cycle. After ready, a read of an unmapped address returns zero with no error.
- R7: All writes are ignored while `ready_o` is 0. After ready, a write to the scratch register (address 3) can be read back.
- R8: The byte-order word (address 0) reads as all ones while `rst_if_o` is 1, and as BOT_PATTERN once the interface phase has ended.
- R9: `rst_if_o` is 1 for the reset state plus IF_RST_CYC cycles. `rst_core_o` is 1 until ready. The reset control word (address 2) shows interface-phase-done in bit 0 and core-reset-active in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| strap_i | input | STRAP_W | Configuration strap levels |
| ld_start_o | output | 1 | One-cycle start pulse to the configuration loader |
| ld_done_i | input | 1 | Loader done pulse |
| ld_bytes_i | input | BYTES_W | Bytes transferred, valid with `ld_done_i` |
| rst_if_o | output | 1 | Interface reset, active high |
| rst_core_o | output | 1 | Core reset, active high |
| ready_o | output | 1 | Sequence complete |
| bus_req_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rvalid_o | output | 1 | Read response valid, one cycle after request |
| bus_rdata_o | output | DATA_W | Read data |
| bus_err_o | output | 1 | Refused-read flag, one cycle |

## Verification
A state machine stuck in or skipping a phase shows at once on `rst_if_o`, `rst_core_o` and `ld_start_o`. A wrong wait counter or target shows as a `ready_o` edge that is early or late against the exact cycle count the bench computes from the loader delay and byte count. A gate that reads the wrong phase shows in the very next read response: all ones against the pattern, a missing or extra error flag, or a scratch value that a dropped write should not have changed. A weak pin filter shows after a short glitch as a falling `ready_o` and a cleared scratch register.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE_RESET  = 3'd0,
      ST_IF_RESET    = 3'd1,
      ST_STRAP_LATCH = 3'd2,
      ST_LOAD_WAIT   = 3'd3,
      ST_READY       = 3'd4
   } rst_state_e;

   // word addresses of the register window
   localparam int unsigned REG_BYTE_ORDER = 0;
   localparam int unsigned REG_HWCFG      = 1;
   localparam int unsigned REG_RSTCTL     = 2;
   localparam int unsigned REG_SCRATCH    = 3;

   // field positions
   localparam int unsigned HWCFG_READY_BIT = 0;
   localparam int unsigned HWCFG_STRAP_LSB = 8;
   localparam int unsigned RSTCTL_IFDONE_BIT = 0;
   localparam int unsigned RSTCTL_CORE_BIT   = 1;

endpackage

// File: rtl/rstseq_pin_filter.sv
module rstseq_pin_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MIN_LOW_CYC = 16
) (
   input  logic clk,
   input  logic por_i,
   input  logic pin_n_i,
   output logic evt_o
);

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i) sync_q <= '1;
      else       sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n_i};
   end

   generate
      if (MIN_LOW_CYC <= 1) begin : g_direct
         assign evt_o = ~sync_q[SYNC_STAGES-1];
      end else begin : g_count
         localparam int unsigned CW = $clog2(MIN_LOW_CYC + 1);
         localparam logic [CW-1:0] LIMIT = CW'(MIN_LOW_CYC);
         logic [CW-1:0] low_cnt_q;

         always_ff @(posedge clk or posedge por_i) begin
            if (por_i)                      low_cnt_q <= '0;
            else if (sync_q[SYNC_STAGES-1]) low_cnt_q <= '0;
            else if (low_cnt_q != LIMIT)    low_cnt_q <= low_cnt_q + 1'b1;
         end

         assign evt_o = (low_cnt_q == LIMIT);
      end
   endgenerate

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
   import rstseq_pkg::*;
#(
   parameter int unsigned STRAP_W       = 8,
   parameter int unsigned BYTES_W       = 16,
   parameter int unsigned CNT_W         = 32,
   parameter int unsigned IF_RST_CYC    = 64,
   parameter int unsigned BASE_WAIT_CYC = 575000,
   parameter int unsigned PER_BYTE_CYC  = 2275
) (
   input  logic               clk,
   input  logic               por_i,
   input  logic               evt_i,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic               ld_done_i,
   input  logic [BYTES_W-1:0] ld_bytes_i,
   output rst_state_e         state_o,
   output logic [STRAP_W-1:0] strap_q_o,
   output logic               ld_start_o,
   output logic               ready_o,
   output logic               rst_if_o,
   output logic               rst_core_o,
   output logic               clr_o
);

   localparam int unsigned PW = CNT_W + BYTES_W + 1;
   localparam logic [CNT_W-1:0] IF_LAST = CNT_W'(IF_RST_CYC - 1);

   rst_state_e         st_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W-1:0]   tgt_q;
   logic               done_seen_q;
   logic [STRAP_W-1:0] strap_q;
   logic [PW-1:0]      tgt_wide;
   logic [CNT_W-1:0]   tgt_sat;

   // wait target: base + bytes * per-byte, clamped to the counter range
   always_comb begin
      tgt_wide = PW'(BASE_WAIT_CYC) + PW'(ld_bytes_i) * PW'(PER_BYTE_CYC);
      tgt_sat  = (|tgt_wide[PW-1:CNT_W]) ? '1 : tgt_wide[CNT_W-1:0];
   end

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i) begin
         st_q        <= ST_IDLE_RESET;
         cnt_q       <= '0;
         tgt_q       <= '0;
         done_seen_q <= 1'b0;
         strap_q     <= '0;
      end else if (evt_i) begin
         st_q        <= ST_IDLE_RESET;
         cnt_q       <= '0;
         tgt_q       <= '0;
         done_seen_q <= 1'b0;
         strap_q     <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE_RESET: begin
               st_q  <= ST_IF_RESET;
               cnt_q <= '0;
            end
            ST_IF_RESET: begin
               if (cnt_q == IF_LAST) begin
                  st_q  <= ST_STRAP_LATCH;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_STRAP_LATCH: begin
               strap_q     <= strap_i;
               st_q        <= ST_LOAD_WAIT;
               cnt_q       <= '0;
               done_seen_q <= 1'b0;
            end
            ST_LOAD_WAIT: begin
               if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
               if (ld_done_i && !done_seen_q) begin
                  done_seen_q <= 1'b1;
                  tgt_q       <= tgt_sat;
               end
               if (done_seen_q && (cnt_q >= tgt_q)) st_q <= ST_READY;
            end
            ST_READY: st_q <= ST_READY;
            default:  st_q <= ST_IDLE_RESET;
         endcase
      end
   end

   assign state_o    = st_q;
   assign strap_q_o  = strap_q;
   assign ld_start_o = (st_q == ST_STRAP_LATCH);
   assign ready_o    = (st_q == ST_READY);
   assign rst_if_o   = (st_q == ST_IDLE_RESET) || (st_q == ST_IF_RESET);
   assign rst_core_o = (st_q != ST_READY);
   assign clr_o      = (st_q == ST_IDLE_RESET);

endmodule

// File: rtl/rstseq_bus_gate.sv
module rstseq_bus_gate
   import rstseq_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned STRAP_W     = 8,
   parameter logic [DATA_W-1:0] BOT_PATTERN = '0
) (
   input  logic               clk,
   input  logic               por_i,
   input  logic               clr_i,
   input  logic               ready_i,
   input  logic               if_done_i,
   input  logic               core_rst_i,
   input  logic [STRAP_W-1:0] strap_q_i,
   input  logic               req_i,
   input  logic               we_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic               rvalid_o,
   output logic [DATA_W-1:0]  rdata_o,
   output logic               err_o
);

   localparam logic [ADDR_W-1:0] A_BOT = ADDR_W'(REG_BYTE_ORDER);
   localparam logic [ADDR_W-1:0] A_HW  = ADDR_W'(REG_HWCFG);
   localparam logic [ADDR_W-1:0] A_RC  = ADDR_W'(REG_RSTCTL);
   localparam logic [ADDR_W-1:0] A_SCR = ADDR_W'(REG_SCRATCH);

   logic [DATA_W-1:0] scratch_q;
   logic [DATA_W-1:0] rd_val;
   logic              early_ok;
   logic              rd_req;
   logic              refuse;

   always_comb begin
      rd_val = '0;
      unique case (addr_i)
         A_BOT: rd_val = if_done_i ? BOT_PATTERN : '1;
         A_HW: begin
            rd_val[HWCFG_READY_BIT]               = ready_i;
            rd_val[HWCFG_STRAP_LSB +: STRAP_W]    = strap_q_i;
         end
         A_RC: begin
            rd_val[RSTCTL_IFDONE_BIT] = if_done_i;
            rd_val[RSTCTL_CORE_BIT]   = core_rst_i;
         end
         A_SCR:   rd_val = scratch_q;
         default: rd_val = '0;
      endcase
   end

   assign early_ok = (addr_i == A_BOT) || (addr_i == A_HW) || (addr_i == A_RC);
   assign rd_req   = req_i && !we_i;
   assign refuse   = !ready_i && !early_ok;

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i) begin
         rvalid_o <= 1'b0;
         rdata_o  <= '0;
         err_o    <= 1'b0;
      end else begin
         rvalid_o <= rd_req;
         err_o    <= rd_req && refuse;
         rdata_o  <= (rd_req && !refuse) ? rd_val : '0;
      end
   end

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i)                                          scratch_q <= '0;
      else if (clr_i)                                     scratch_q <= '0;
      else if (req_i && we_i && ready_i && addr_i == A_SCR) scratch_q <= wdata_i;
   end

endmodule

// File: rtl/chip_reset_sequencer.sv
module chip_reset_sequencer
   import rstseq_pkg::*;
#(
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned ADDR_W        = 4,
   parameter int unsigned STRAP_W       = 8,
   parameter int unsigned BYTES_W       = 16,
   parameter int unsigned CNT_W         = 32,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned MIN_LOW_CYC   = 16,
   parameter int unsigned IF_RST_CYC    = 64,
   parameter int unsigned BASE_WAIT_CYC = 575000,
   parameter int unsigned PER_BYTE_CYC  = 2275,
   parameter logic [DATA_W-1:0] BOT_PATTERN = 32'hC3A5_5A3C
) (
   input  logic               clk,
   input  logic               por_i,
   input  logic               ext_rst_n_i,
   input  logic [STRAP_W-1:0] strap_i,
   output logic               ld_start_o,
   input  logic               ld_done_i,
   input  logic [BYTES_W-1:0] ld_bytes_i,
   output logic               rst_if_o,
   output logic               rst_core_o,
   output logic               ready_o,
   input  logic               bus_req_i,
   input  logic               bus_we_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   output logic               bus_rvalid_o,
   output logic [DATA_W-1:0]  bus_rdata_o,
   output logic               bus_err_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (IF_RST_CYC < 1 || IF_RST_CYC >= (64'd1 << CNT_W)) begin : g_bad_if
         $error("IF_RST_CYC must be in 1 .. 2**CNT_W-1");
      end
      if (HWCFG_STRAP_LSB + STRAP_W > DATA_W) begin : g_bad_strap
         $error("strap field does not fit the data word");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must cover four registers");
      end
   endgenerate

   logic               pin_evt;
   rst_state_e         fsm_state;
   logic [STRAP_W-1:0] strap_q;
   logic               clr;

   rstseq_pin_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .MIN_LOW_CYC (MIN_LOW_CYC)
   ) u_pin (
      .clk     (clk),
      .por_i   (por_i),
      .pin_n_i (ext_rst_n_i),
      .evt_o   (pin_evt)
   );

   rstseq_ctrl #(
      .STRAP_W       (STRAP_W),
      .BYTES_W       (BYTES_W),
      .CNT_W         (CNT_W),
      .IF_RST_CYC    (IF_RST_CYC),
      .BASE_WAIT_CYC (BASE_WAIT_CYC),
      .PER_BYTE_CYC  (PER_BYTE_CYC)
   ) u_ctrl (
      .clk        (clk),
      .por_i      (por_i),
      .evt_i      (pin_evt),
      .strap_i    (strap_i),
      .ld_done_i  (ld_done_i),
      .ld_bytes_i (ld_bytes_i),
      .state_o    (fsm_state),
      .strap_q_o  (strap_q),
      .ld_start_o (ld_start_o),
      .ready_o    (ready_o),
      .rst_if_o   (rst_if_o),
      .rst_core_o (rst_core_o),
      .clr_o      (clr)
   );

   rstseq_bus_gate #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .STRAP_W     (STRAP_W),
      .BOT_PATTERN (BOT_PATTERN)
   ) u_gate (
      .clk        (clk),
      .por_i      (por_i),
      .clr_i      (clr),
      .ready_i    (ready_o),
      .if_done_i  (!rst_if_o),
      .core_rst_i (rst_core_o),
      .strap_q_i  (strap_q),
      .req_i      (bus_req_i),
      .we_i       (bus_we_i),
      .addr_i     (bus_addr_i),
      .wdata_i    (bus_wdata_i),
      .rvalid_o   (bus_rvalid_o),
      .rdata_o    (bus_rdata_o),
      .err_o      (bus_err_o)
   );

endmodule

// File: rtl/chip_reset_sequencer_chk.sv
module chip_reset_sequencer_chk #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              por_i,
   input logic              ld_start_o,
   input logic              ld_done_i,
   input logic              rst_if_o,
   input logic              rst_core_o,
   input logic              ready_o,
   input logic              bus_req_i,
   input logic              bus_we_i,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic              bus_rvalid_o,
   input logic [DATA_W-1:0] bus_rdata_o,
   input logic              bus_err_o
);

   logic done_since_start;

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i)           done_since_start <= 1'b0;
      else if (ld_start_o) done_since_start <= 1'b0;
      else if (ld_done_i)  done_since_start <= 1'b1;
   end

   p_start_pulse_r4: assert property (@(posedge clk) disable iff (por_i)
      ld_start_o |=> !ld_start_o);

   p_start_after_if_r4: assert property (@(posedge clk) disable iff (por_i)
      ld_start_o |-> !rst_if_o);

   p_ready_needs_done_r5: assert property (@(posedge clk) disable iff (por_i)
      ready_o |-> done_since_start);

   p_refused_read_r6: assert property (@(posedge clk) disable iff (por_i)
      (bus_req_i && !bus_we_i && !ready_o && bus_addr_i == ADDR_W'(3))
      |=> (bus_err_o && bus_rdata_o == '0));

   p_err_with_valid_r6: assert property (@(posedge clk) disable iff (por_i)
      bus_err_o |-> bus_rvalid_o);

   p_bot_ones_r8: assert property (@(posedge clk) disable iff (por_i)
      (bus_req_i && !bus_we_i && rst_if_o && bus_addr_i == ADDR_W'(0))
      |=> bus_rdata_o == '1);

   p_core_covers_if_r9: assert property (@(posedge clk) disable iff (por_i)
      rst_if_o |-> rst_core_o);

endmodule

bind chip_reset_sequencer chip_reset_sequencer_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk          (clk),
   .por_i        (por_i),
   .ld_start_o   (ld_start_o),
   .ld_done_i    (ld_done_i),
   .rst_if_o     (rst_if_o),
   .rst_core_o   (rst_core_o),
   .ready_o      (ready_o),
   .bus_req_i    (bus_req_i),
   .bus_we_i     (bus_we_i),
   .bus_addr_i   (bus_addr_i),
   .bus_rvalid_o (bus_rvalid_o),
   .bus_rdata_o  (bus_rdata_o),
   .bus_err_o    (bus_err_o)
);

// File: tb/chip_reset_sequencer_tb.sv
module chip_reset_sequencer_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 4;
   localparam int STRAP_W = 8;
   localparam int BYTES_W = 8;
   localparam int MIN_LOW = 4;
   localparam int IF_CYC = 8;
   localparam int BASE = 20;
   localparam int PER_BYTE = 3;
   localparam logic [31:0] PATTERN = 32'hC3A5_5A3C;

   logic clk = 1'b0;
   logic por_i = 1'b1;
   logic ext_rst_n_i = 1'b1;
   logic [STRAP_W-1:0] strap_i = '0;
   logic ld_start_o;
   logic ld_done_i = 1'b0;
   logic [BYTES_W-1:0] ld_bytes_i = '0;
   logic rst_if_o, rst_core_o, ready_o;
   logic bus_req_i = 1'b0;
   logic bus_we_i = 1'b0;
   logic [ADDR_W-1:0] bus_addr_i = '0;
   logic [DATA_W-1:0] bus_wdata_i = '0;
   logic bus_rvalid_o;
   logic [DATA_W-1:0] bus_rdata_o;
   logic bus_err_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   chip_reset_sequencer #(
      .DATA_W (DATA_W), .ADDR_W (ADDR_W), .STRAP_W (STRAP_W),
      .BYTES_W (BYTES_W), .CNT_W (16), .SYNC_STAGES (2),
      .MIN_LOW_CYC (MIN_LOW), .IF_RST_CYC (IF_CYC),
      .BASE_WAIT_CYC (BASE), .PER_BYTE_CYC (PER_BYTE),
      .BOT_PATTERN (PATTERN)
   ) u_dut (
      .clk (clk), .por_i (por_i), .ext_rst_n_i (ext_rst_n_i),
      .strap_i (strap_i), .ld_start_o (ld_start_o), .ld_done_i (ld_done_i),
      .ld_bytes_i (ld_bytes_i), .rst_if_o (rst_if_o), .rst_core_o (rst_core_o),
      .ready_o (ready_o), .bus_req_i (bus_req_i), .bus_we_i (bus_we_i),
      .bus_addr_i (bus_addr_i), .bus_wdata_i (bus_wdata_i),
      .bus_rvalid_o (bus_rvalid_o), .bus_rdata_o (bus_rdata_o),
      .bus_err_o (bus_err_o)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // cycle monitor and loader model, all at the falling edge
   int cyc = 0;
   int starts = 0;
   int start_hi = 0;
   int start_cyc = 0;
   int rise_cyc = 0;
   int done_cyc = 0;
   logic rdy_prev = 1'b0;
   logic st_prev = 1'b0;
   int ld_dly = 3;
   int ld_nb = 0;
   int cd = 0;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (ld_start_o) begin
         start_hi = start_hi + 1;
         if (!st_prev) begin
            starts = starts + 1;
            start_cyc = cyc;
         end
      end
      if (ready_o && !rdy_prev) rise_cyc = cyc;
      st_prev = ld_start_o;
      rdy_prev = ready_o;
      ld_done_i = 1'b0;
      if (ld_start_o) cd = ld_dly;
      else if (cd > 0) begin
         cd = cd - 1;
         if (cd == 0) begin
            ld_done_i = 1'b1;
            ld_bytes_i = BYTES_W'(ld_nb);
            done_cyc = cyc;
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_read(input int a, output logic [31:0] d, output logic e, output logic v);
      @(negedge clk);
      bus_req_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = ADDR_W'(a);
      @(negedge clk);
      d = bus_rdata_o; e = bus_err_o; v = bus_rvalid_o;
      bus_req_i = 1'b0;
   endtask

   task automatic bus_write(input int a, input logic [31:0] wd);
      @(negedge clk);
      bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = ADDR_W'(a); bus_wdata_i = wd;
      @(negedge clk);
      bus_req_i = 1'b0; bus_we_i = 1'b0;
   endtask

   task automatic wait_ready();
      while (!ready_o) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic wait_starts(input int n);
      while (starts < n) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic pin_pulse(input int n);
      @(negedge clk);
      ext_rst_n_i = 1'b0;
      repeat (n) @(negedge clk);
      ext_rst_n_i = 1'b1;
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      check("R1 ready in por", 32'(ready_o), 32'd0);
      check("R9 if reset in por", 32'(rst_if_o), 32'd1);
      check("R9 core reset in por", 32'(rst_core_o), 32'd1);
      check("R4 no start in por", 32'(ld_start_o), 32'd0);
   endtask

   task automatic t_power_up();
      logic [31:0] d; logic e, v;
      strap_i = 8'h5A; ld_dly = 3; ld_nb = 4;
      @(negedge clk); por_i = 1'b0;
      bus_read(0, d, e, v);
      check("R8 bot ones in if phase", d, 32'hFFFF_FFFF);
      check("R6 bot no err", 32'(e), 32'd0);
      bus_read(2, d, e, v);
      check("R9 rstctl early", d, 32'h2);
      bus_read(3, d, e, v);
      check("R6 refused data", d, 32'd0);
      check("R6 refused err", 32'(e), 32'd1);
      check("R6 refused valid", 32'(v), 32'd1);
      @(negedge clk);
      check("R6 err one cycle", 32'(bus_err_o), 32'd0);
      bus_write(3, 32'h1234_5678);
      while (rst_if_o) @(negedge clk);
      bus_read(0, d, e, v);
      check("R8 bot pattern", d, PATTERN);
      wait_starts(1);
      bus_read(1, d, e, v);
      check("R3 straps latched", d, 32'h5A00);
      strap_i = 8'hFF;
      wait_ready();
      check("R5 early done timing", 32'(rise_cyc - start_cyc), 32'(BASE + 4*PER_BYTE + 2));
      bus_read(1, d, e, v);
      check("R3 straps held + R5 ready bit", d, 32'h5A01);
      bus_read(3, d, e, v);
      check("R7 early write dropped", d, 32'd0);
      check("R4 one start", 32'(starts), 32'd1);
      check("R4 start width", 32'(start_hi), 32'd1);
   endtask

   task automatic t_ready_access();
      logic [31:0] d; logic e, v;
      bus_write(3, 32'hA5A5_0F0F);
      bus_read(3, d, e, v);
      check("R7 scratch write", d, 32'hA5A5_0F0F);
      check("R6 no err after ready", 32'(e), 32'd0);
      bus_read(5, d, e, v);
      check("R6 unmapped data", d, 32'd0);
      check("R6 unmapped no err", 32'(e), 32'd0);
      bus_read(2, d, e, v);
      check("R9 rstctl ready", d, 32'h1);
      check("R9 core released", 32'(rst_core_o), 32'd0);
   endtask

   task automatic t_short_glitch();
      logic [31:0] d; logic e, v;
      pin_pulse(MIN_LOW - 1);
      repeat (10) @(negedge clk);
      check("R2 ready kept", 32'(ready_o), 32'd1);
      bus_read(3, d, e, v);
      check("R2 scratch kept", d, 32'hA5A5_0F0F);
   endtask

   task automatic t_pin_reset_late_load();
      logic [31:0] d; logic e, v;
      strap_i = 8'h3C; ld_dly = 40; ld_nb = 0;
      @(negedge clk); ext_rst_n_i = 1'b0;
      repeat (12) @(negedge clk);
      check("R1 ready low on pin", 32'(ready_o), 32'd0);
      check("R1 if reset on pin", 32'(rst_if_o), 32'd1);
      check("R1 core reset on pin", 32'(rst_core_o), 32'd1);
      ext_rst_n_i = 1'b1;
      wait_ready();
      check("R5 late done timing", 32'(rise_cyc - done_cyc), 32'd2);
      bus_read(3, d, e, v);
      check("R1 scratch cleared", d, 32'd0);
      bus_read(1, d, e, v);
      check("R3 new straps", d, 32'h3C01);
      check("R4 second start", 32'(starts), 32'd2);
   endtask

   task automatic t_reset_mid_load();
      ld_dly = 30; ld_nb = 2;
      pin_pulse(12);
      wait_starts(3);
      repeat (10) @(negedge clk);
      check("R5 not ready before done", 32'(ready_o), 32'd0);
      ld_dly = 3;
      pin_pulse(12);
      wait_ready();
      check("R1 restart start count", 32'(starts), 32'd4);
      check("R5 timing after restart", 32'(rise_cyc - start_cyc), 32'(BASE + 2*PER_BYTE + 2));
      check("R4 start width total", 32'(start_hi), 32'd4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      t_power_up();
      t_ready_access();
      t_short_glitch();
      t_pin_reset_late_load();
      t_reset_mid_load();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule